// File: doc/BRIEF.md
# Pipelined External-Memory Trigger Scheduler

This block sits between a processor core and an external memory port. The core raises access triggers of three kinds: DRAM refresh, write transfer and read transfer. The block turns them into a sequence of external accesses. One access runs on the memory side while at most one read/write trigger waits in a holding slot, with its own address and data register. A separate refresh flag can wait beside that slot. The block works in instruction cycles of two clocks. An access of a given kind lasts N instruction cycles, where N is its clock count rounded up to whole instruction cycles.

A trigger that reaches a completely idle block goes straight to the access stage. Its address-calculation strobe fires on the next instruction-cycle boundary, and the access starts in the clock after that strobe. A trigger that arrives while the block is occupied goes into the holding slot. It receives its address-calculation strobe while the current access is still running, then waits until that access finishes. A newer read/write trigger overwrites whatever the slot holds. When an access ends, a waiting refresh goes before a waiting read/write. The core can therefore issue two triggers back to back from idle without reading any status.

Top module: `xmem_trig_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, buf_full, acc_active, acc_start, acc_done and calc_stb are all 0.
- R2: A read/write trigger sampled while the block is fully idle (no refresh request in the same cycle) makes busy 1 in the next cycle, and buf_full stays 0. calc_stb with calc_addr equal to the trigger address appears one or two cycles after the sampling edge (the next instruction-cycle boundary). acc_start is high in the cycle right after that strobe.
- R3: Each access holds acc_active for exactly 2*ceil(C/2) clocks, where C is the clock parameter for its kind. acc_start is high in the first of those clocks and acc_done in the last, never both in the same cycle.
- R4: Two read/write triggers in consecutive cycles from idle, in any read/write mix, are both executed, in arrival order.
- R5: A read/write trigger that arrives while the holding slot is occupied replaces the slot's content, and the replaced trigger never produces an access.
- R6: When a refresh and a read/write are both waiting as an access ends, the refresh access is issued first and the read/write follows it.
- R7: acc_start is only raised when no access was active in the previous cycle, or when the previous cycle carried acc_done.
- R8: busy is 1 while an access is running or anything waits, and it drops only in the cycle after an acc_done. buf_full is 1 while the holding slot or the refresh flag is occupied.
- R9: A trigger that waits behind a running access receives its calc_stb while acc_active is still 1. It starts in the cycle right after the running access's acc_done.
- R10: acc_kind reports 1 for read, 2 for write and 3 for refresh (rw_is_write=1 selects write). acc_addr and acc_wdata carry the trigger's address and data (zero for refresh). All three hold steady for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rw_req | input | 1 | Read/write trigger, one cycle per trigger |
| rw_is_write | input | 1 | 1 selects write, 0 selects read |
| rw_addr | input | AW | Trigger address |
| rw_wdata | input | DW | Trigger data |
| rfsh_req | input | 1 | Refresh trigger |
| busy | output | 1 | Access running or waiting |
| buf_full | output | 1 | Holding slot or refresh flag occupied |
| calc_stb | output | 1 | Address-calculation strobe |
| calc_addr | output | AW | Address under calculation |
| acc_start | output | 1 | First clock of an access |
| acc_done | output | 1 | Last clock of an access |
| acc_active | output | 1 | External access in progress |
| acc_kind | output | 2 | Kind of the running access |
| acc_addr | output | AW | Address of the running access |
| acc_wdata | output | DW | Data of the running access |

## Verification
The bound checker watches four things on every cycle. It checks that a new access never begins while the previous one is still running, and that the kind, address and data stay frozen during an access. It also checks that acc_done always closes an access and never coincides with a start, and that busy falls only right after an access has finished. The bench scenarios cover what a single-cycle property cannot see. These are the arrival ordering of back-to-back triggers, the loss of a replaced trigger, refresh overtaking a waiting read, the trigger-to-strobe-to-start timing from idle, the per-kind access lengths, and the overlap of the waiting trigger's address calculation with the running access.

// File: rtl/xts_pkg.sv
`timescale 1ns/1ps
package xts_pkg;

  typedef enum logic [1:0] {
    XK_NONE  = 2'd0,
    XK_READ  = 2'd1,
    XK_WRITE = 2'd2,
    XK_RFSH  = 2'd3
  } xk_e;

  // clock count rounded up to whole two-clock instruction cycles
  function automatic int run_clks(input int clks);
    return 2 * ((clks + 1) / 2);
  endfunction

endpackage

// File: rtl/xts_phase.sv
`timescale 1ns/1ps
module xts_phase (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  logic tick_q, tick_d;

  always_comb begin
    tick_d = ~tick_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
    end
  end

  // second clock of each instruction cycle
  assign tick = tick_q;

endmodule

// File: rtl/xts_hold_slot.sv
`timescale 1ns/1ps
module xts_hold_slot import xts_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  xk_e           load_kind,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  input  logic          take,
  input  logic          calc_go,
  output logic          vld,
  output logic          calc_done,
  output xk_e           kind,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);

  logic          vld_q, vld_d;
  logic          cdn_q, cdn_d;
  xk_e           kind_q, kind_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          en;

  assign en = load | take | calc_go;

  always_comb begin
    vld_d  = vld_q;
    cdn_d  = cdn_q;
    kind_d = kind_q;
    addr_d = addr_q;
    data_d = data_q;
    if (load) begin
      // newer trigger overwrites, calculation restarts
      vld_d  = 1'b1;
      cdn_d  = 1'b0;
      kind_d = load_kind;
      addr_d = load_addr;
      data_d = load_data;
    end else if (take) begin
      vld_d = 1'b0;
      cdn_d = 1'b0;
    end else if (calc_go) begin
      cdn_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      cdn_q  <= 1'b0;
      kind_q <= XK_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else if (en) begin
      vld_q  <= vld_d;
      cdn_q  <= cdn_d;
      kind_q <= kind_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign vld       = vld_q;
  assign calc_done = cdn_q;
  assign kind      = kind_q;
  assign addr      = addr_q;
  assign data      = data_q;

endmodule

// File: rtl/xts_access.sv
`timescale 1ns/1ps
module xts_access import xts_pkg::*; #(
  parameter int AW      = 16,
  parameter int DW      = 24,
  parameter int RD_CLKS = 5,
  parameter int WR_CLKS = 4,
  parameter int RF_CLKS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_run,
  input  xk_e           load_kind,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  input  logic          calc_go,
  output logic          vld,
  output logic          run,
  output logic          first,
  output logic          last,
  output xk_e           kind,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);

  localparam int RD_LEN = run_clks(RD_CLKS);
  localparam int WR_LEN = run_clks(WR_CLKS);
  localparam int RF_LEN = run_clks(RF_CLKS);
  localparam int MX_A   = (RD_LEN > WR_LEN) ? RD_LEN : WR_LEN;
  localparam int MX_LEN = (MX_A > RF_LEN) ? MX_A : RF_LEN;
  localparam int CW     = $clog2(MX_LEN) + 1;

  logic [CW-1:0] len_tab [0:3];

  for (genvar k = 0; k < 4; k++) begin : g_len
    localparam int L = (k == 3) ? RF_LEN : (k == 2) ? WR_LEN : RD_LEN;
    assign len_tab[k] = CW'(L - 1);
  end

  logic          vld_q, vld_d;
  logic          run_q, run_d;
  logic          fst_q, fst_d;
  logic [CW-1:0] cnt_q, cnt_d;
  xk_e           kind_q, kind_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic [1:0]    ld_sel, cur_sel;
  logic          en;

  assign ld_sel  = load_kind;
  assign cur_sel = kind_q;
  assign last    = vld_q & run_q & (cnt_q == '0);
  assign en      = load | calc_go | last | run_q;

  always_comb begin
    vld_d  = vld_q;
    run_d  = run_q;
    cnt_d  = cnt_q;
    fst_d  = 1'b0;
    kind_d = kind_q;
    addr_d = addr_q;
    data_d = data_q;
    if (load) begin
      vld_d  = 1'b1;
      run_d  = load_run;
      fst_d  = load_run;
      cnt_d  = len_tab[ld_sel];
      kind_d = load_kind;
      addr_d = load_addr;
      data_d = load_data;
    end else if (calc_go) begin
      run_d = 1'b1;
      fst_d = 1'b1;
      cnt_d = len_tab[cur_sel];
    end else if (last) begin
      vld_d = 1'b0;
      run_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst_q <= 1'b0;
    end else begin
      fst_q <= fst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
      kind_q <= XK_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else if (en) begin
      vld_q  <= vld_d;
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign vld   = vld_q;
  assign run   = run_q;
  assign first = fst_q;
  assign kind  = kind_q;
  assign addr  = addr_q;
  assign data  = data_q;

endmodule

// File: rtl/xmem_trig_sched.sv
`timescale 1ns/1ps
module xmem_trig_sched import xts_pkg::*; #(
  parameter int AW      = 16,
  parameter int DW      = 24,
  parameter int RD_CLKS = 5,
  parameter int WR_CLKS = 4,
  parameter int RF_CLKS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rw_req,
  input  logic          rw_is_write,
  input  logic [AW-1:0] rw_addr,
  input  logic [DW-1:0] rw_wdata,
  input  logic          rfsh_req,
  output logic          busy,
  output logic          buf_full,
  output logic          calc_stb,
  output logic [AW-1:0] calc_addr,
  output logic          acc_start,
  output logic          acc_done,
  output logic          acc_active,
  output logic [1:0]    acc_kind,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata
);

  logic          tick;
  logic          rf_q, rf_d;

  logic          p_vld, p_cdn;
  xk_e           p_kind;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;

  logic          a_vld, a_run, a_first, a_last;
  xk_e           a_kind;
  logic [AW-1:0] a_addr;
  logic [DW-1:0] a_data;

  xk_e           req_kind;
  logic          idle_all, bypass, p_load, mem_free;
  logic          a_calc, p_calc, start_rf, start_p;
  logic          a_load, a_load_run;
  xk_e           a_ld_kind;
  logic [AW-1:0] a_ld_addr;
  logic [DW-1:0] a_ld_data;

  xts_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  // ---------------- arbitration ----------------
  always_comb begin
    req_kind = rw_is_write ? XK_WRITE : XK_READ;
    idle_all = ~a_vld & ~p_vld & ~rf_q;
    bypass   = rw_req & idle_all & ~rfsh_req;
    p_load   = rw_req & ~bypass;
    mem_free = ~a_vld | a_last;
    // one address calculation per instruction cycle, access stage first
    a_calc   = tick & a_vld & ~a_run;
    p_calc   = tick & p_vld & ~p_cdn & ~a_calc;
    // refresh outranks a waiting read/write
    start_rf = tick & mem_free & rf_q;
    start_p  = tick & mem_free & ~rf_q & p_vld & (p_cdn | p_calc);
    a_load     = start_rf | start_p | bypass;
    a_load_run = start_rf | start_p;
    if (start_rf) begin
      a_ld_kind = XK_RFSH;
      a_ld_addr = '0;
      a_ld_data = '0;
    end else if (start_p) begin
      a_ld_kind = p_kind;
      a_ld_addr = p_addr;
      a_ld_data = p_data;
    end else begin
      a_ld_kind = req_kind;
      a_ld_addr = rw_addr;
      a_ld_data = rw_wdata;
    end
  end

  // ---------------- refresh flag ----------------
  always_comb begin
    rf_d = rfsh_req | (rf_q & ~start_rf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_q <= 1'b0;
    end else begin
      rf_q <= rf_d;
    end
  end

  xts_hold_slot #(
    .AW (AW),
    .DW (DW)
  ) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (p_load),
    .load_kind (req_kind),
    .load_addr (rw_addr),
    .load_data (rw_wdata),
    .take      (start_p),
    .calc_go   (p_calc),
    .vld       (p_vld),
    .calc_done (p_cdn),
    .kind      (p_kind),
    .addr      (p_addr),
    .data      (p_data)
  );

  xts_access #(
    .AW      (AW),
    .DW      (DW),
    .RD_CLKS (RD_CLKS),
    .WR_CLKS (WR_CLKS),
    .RF_CLKS (RF_CLKS)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (a_load),
    .load_run  (a_load_run),
    .load_kind (a_ld_kind),
    .load_addr (a_ld_addr),
    .load_data (a_ld_data),
    .calc_go   (a_calc),
    .vld       (a_vld),
    .run       (a_run),
    .first     (a_first),
    .last      (a_last),
    .kind      (a_kind),
    .addr      (a_addr),
    .data      (a_data)
  );

  // ---------------- outputs ----------------
  assign busy       = a_vld | p_vld | rf_q;
  assign buf_full   = p_vld | rf_q;
  assign calc_stb   = a_calc | p_calc;
  assign calc_addr  = a_calc ? a_addr : p_addr;
  assign acc_start  = a_first;
  assign acc_done   = a_last;
  assign acc_active = a_run;
  assign acc_kind   = a_kind;
  assign acc_addr   = a_addr;
  assign acc_wdata  = a_data;

endmodule

// File: rtl/xmem_trig_sched_chk.sv
`timescale 1ns/1ps
module xmem_trig_sched_chk #(
  parameter int AW = 16,
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          acc_start,
  input logic          acc_done,
  input logic          acc_active,
  input logic [1:0]    acc_kind,
  input logic [AW-1:0] acc_addr,
  input logic [DW-1:0] acc_wdata
);

  p_one_at_a_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |-> (!$past(acc_active) || $past(acc_done)));

  p_fields_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_active && !acc_start) |->
      ($stable(acc_kind) && $stable(acc_addr) && $stable(acc_wdata)));

  p_done_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> (!acc_active || acc_start));

  p_done_not_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> (acc_active && !acc_start));

  p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(acc_done));

endmodule

bind xmem_trig_sched xmem_trig_sched_chk #(
  .AW (AW),
  .DW (DW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .acc_start  (acc_start),
  .acc_done   (acc_done),
  .acc_active (acc_active),
  .acc_kind   (acc_kind),
  .acc_addr   (acc_addr),
  .acc_wdata  (acc_wdata)
);

// File: tb/xmem_trig_sched_tb.sv
`timescale 1ns/1ps
module xmem_trig_sched_tb;

  localparam int AW  = 16;
  localparam int DW  = 24;
  localparam int RDC = 5;
  localparam int WRC = 4;
  localparam int RFC = 3;

  logic          clk, rst_n;
  logic          rw_req, rw_is_write, rfsh_req;
  logic [AW-1:0] rw_addr;
  logic [DW-1:0] rw_wdata;
  logic          busy, buf_full, calc_stb, acc_start, acc_done, acc_active;
  logic [AW-1:0] calc_addr, acc_addr;
  logic [DW-1:0] acc_wdata;
  logic [1:0]    acc_kind;

  typedef struct {
    logic [1:0]    k;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } exp_t;

  exp_t exp_q[$];
  exp_t e;

  int checks, failures, cyc;
  int st_cyc, last_done, gap;
  logic [1:0] st_kind;
  logic [AW-1:0] target_addr;
  bit calc_hit, finished;

  xmem_trig_sched #(
    .AW (AW), .DW (DW), .RD_CLKS (RDC), .WR_CLKS (WRC), .RF_CLKS (RFC)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .rw_req (rw_req), .rw_is_write (rw_is_write),
    .rw_addr (rw_addr), .rw_wdata (rw_wdata), .rfsh_req (rfsh_req),
    .busy (busy), .buf_full (buf_full), .calc_stb (calc_stb), .calc_addr (calc_addr),
    .acc_start (acc_start), .acc_done (acc_done), .acc_active (acc_active),
    .acc_kind (acc_kind), .acc_addr (acc_addr), .acc_wdata (acc_wdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int exp_len(input logic [1:0] k);
    case (k)
      2'd1:    return 2 * ((RDC + 1) / 2);
      2'd2:    return 2 * ((WRC + 1) / 2);
      default: return 2 * ((RFC + 1) / 2);
    endcase
  endfunction

  function automatic void push(input logic [1:0] k, input logic [AW-1:0] a,
                               input logic [DW-1:0] d);
    exp_t x;
    x.k = k; x.a = a; x.d = d;
    exp_q.push_back(x);
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (calc_stb && acc_active && calc_addr == target_addr) calc_hit = 1'b1;
      if (acc_start) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "start with nothing expected", longint'(acc_addr), 0);
        end else begin
          e = exp_q.pop_front();
          chk(acc_kind == e.k, "R4", "order/kind", acc_kind, e.k);
          chk(acc_addr == e.a, "R10", "access address", acc_addr, e.a);
          if (e.k == 2'd2)
            chk(acc_wdata == e.d, "R10", "write data", acc_wdata, e.d);
        end
        st_cyc  = cyc;
        st_kind = acc_kind;
        gap     = cyc - last_done;
      end
      if (acc_done) begin
        chk(cyc - st_cyc + 1 == exp_len(st_kind), "R3", "access length",
            cyc - st_cyc + 1, exp_len(st_kind));
        last_done = cyc;
      end
    end
  end

  task automatic drive_rw(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    rw_req = 1'b1; rw_is_write = wr; rw_addr = a; rw_wdata = d;
    @(negedge clk);
    rw_req = 1'b0;
  endtask

  task automatic drive_rf();
    rfsh_req = 1'b1;
    @(negedge clk);
    rfsh_req = 1'b0;
  endtask

  task automatic wait_start();
    for (int i = 0; i < 50 && !acc_start; i++) @(negedge clk);
  endtask

  task automatic wait_quiet(input string req);
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    chk(exp_q.size() == 0, req, "expected accesses left over", exp_q.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    checks = 0; failures = 0; cyc = 0; finished = 0;
    st_cyc = 0; last_done = 0; gap = 0; st_kind = 2'd0;
    target_addr = '1; calc_hit = 0;
    rst_n = 1'b0; rw_req = 0; rw_is_write = 0; rw_addr = '0; rw_wdata = '0; rfsh_req = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !buf_full, "R1", "flags in reset", {busy, buf_full}, 0);
    chk(!acc_active && !acc_start && !acc_done && !calc_stb, "R1", "strobes in reset",
        {acc_active, acc_start, acc_done, calc_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !acc_active && !calc_stb, "R1", "first cycle after reset",
        {busy, acc_active, calc_stb}, 0);

    // S1: single read from idle, R2 timing
    begin
      int k;
      push(2'd1, 16'h1111, 24'h0);
      drive_rw(1'b0, 16'h1111, 24'h0);
      chk(busy == 1'b1, "R2", "busy after first trigger", busy, 1);
      chk(buf_full == 1'b0, "R2", "slot empty after first trigger", buf_full, 0);
      k = 1;
      while (!calc_stb && k < 3) begin @(negedge clk); k++; end
      chk(calc_stb && k <= 2, "R2", "calc within next instruction cycle", k, 2);
      chk(calc_addr == 16'h1111, "R2", "calc address", calc_addr, 16'h1111);
      @(negedge clk);
      chk(acc_start == 1'b1, "R2", "start right after calc", acc_start, 1);
      for (int i = 0; i < 20 && !acc_done; i++) @(negedge clk);
      @(negedge clk);
      chk(!busy && !buf_full, "R8", "busy clears after last done", busy, 0);
      wait_quiet("R2");
    end

    // S2: single write from idle
    push(2'd2, 16'h2222, 24'hABCDEF);
    drive_rw(1'b1, 16'h2222, 24'hABCDEF);
    wait_quiet("R3");

    // S3: two back-to-back triggers from idle, write then read
    push(2'd2, 16'h3030, 24'h123456);
    push(2'd1, 16'h3131, 24'h0);
    rw_req = 1'b1; rw_is_write = 1'b1; rw_addr = 16'h3030; rw_wdata = 24'h123456;
    @(negedge clk);
    drive_rw(1'b0, 16'h3131, 24'h0);
    chk(buf_full == 1'b1, "R8", "second trigger waits in slot", buf_full, 1);
    wait_quiet("R4");

    // S4: replacement and overlap
    push(2'd1, 16'h4000, 24'h0);
    drive_rw(1'b0, 16'h4000, 24'h0);
    wait_start();
    drive_rw(1'b1, 16'h4111, 24'h777777);
    target_addr = 16'h4222;
    calc_hit = 1'b0;
    push(2'd1, 16'h4222, 24'h0);
    drive_rw(1'b0, 16'h4222, 24'h0);
    wait_quiet("R5");
    chk(calc_hit, "R9", "waiting calc overlaps running access", calc_hit, 1);
    chk(gap == 1, "R9", "start right after done", gap, 1);

    // S5: refresh overtakes a waiting read
    push(2'd2, 16'h5000, 24'h0F0F0F);
    drive_rw(1'b1, 16'h5000, 24'h0F0F0F);
    wait_start();
    drive_rw(1'b0, 16'h5111, 24'h0);
    drive_rf();
    chk(buf_full == 1'b1, "R8", "both waiting", buf_full, 1);
    push(2'd3, 16'h0000, 24'h0);
    push(2'd1, 16'h5111, 24'h0);
    wait_quiet("R6");

    // S6: refresh from idle
    push(2'd3, 16'h0000, 24'h0);
    drive_rf();
    wait_quiet("R3");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL R4 watchdog expired: actual=%0d expected=idle", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule